// File: doc/BRIEF.md
# Genetic Mating Step: Tournament Selection, Two-Point Crossover and Mutation

This unit carries out one mating step of a genetic search over a population of chromosomes held outside it. Each chromosome packs one gene pair per antenna element into 12 bits. Element e occupies bits 12e to 12e+11: the low 8 bits are the Gray-coded phase gene and the high 4 bits are the Gray-coded magnitude gene. The unit never converts these genes. Selection, crossover and mutation all work on the stored bit pattern as it is.

A pulse on `start` launches a run, and every run uses the same steps. A 32-bit LFSR supplies one random draw per busy cycle. Two binary tournaments choose two distinct parents by fitness. A segment with random bounds is swapped between the parents to give two offspring. A mutation pass then picks one chromosome of the population, decides with a programmable probability whether to mutate it, and inverts a programmable number of randomly placed bits. The mutated chromosome is returned through a write port. The index of the current best individual is latched at start, and that chromosome is never mutated.

Top module: `ga_mate_unit`

## Requirements
- R1: After reset, `busy`, `done` and `mut_we` are 0 and the LFSR holds the value 1.
- R2: The LFSR is a right-shifting Galois register: the next state is `{0, s[31:1]}` XOR (`s[0]` ? 32'h80200003 : 0). It steps once in every busy cycle, and each draw uses the value it holds before that step. It does not step while idle. A `seed_load` pulse while idle loads `seed`, and a zero seed loads 1 instead.
- R3: An index draw takes the low $clog2(POP) bits of the LFSR. A value of POP or more is rejected, and the draw repeats in the next cycle.
- R4: A tournament draws two indices, first then second. The second candidate wins only when its unsigned fitness is strictly greater, so a tie keeps the first candidate. Parent A comes from the first tournament.
- R5: If the second tournament returns parent A, the whole second tournament runs again. `par_a` and `par_b` always differ.
- R6: Each crossover point draw takes the low $clog2(12·NELEM) bits and rejects values of 12·NELEM or more. The segment runs from the smaller point to the larger point, both ends included, so equal points give a one-bit segment.
- R7: Crossover happens on every run. `child_a` is parent A with its segment bits taken from parent B, and `child_b` is the converse.
- R8: After crossover, an index draw chooses the chromosome to mutate. If it equals `best_idx` as latched at start, the run ends with no write.
- R9: Otherwise one gate draw follows. Mutation proceeds only if the low 8 LFSR bits are below `mut_prob` as latched at start. Otherwise the run ends with no write, so a `mut_prob` of 0 never mutates.
- R10: A mutation makes `mut_flips` position draws (with the R6 rejection), and each one inverts that bit of the chosen chromosome. `mut_we` then pulses with `mut_idx` and `mut_data` carrying the result. A count of 0 writes the chromosome back unchanged.
- R11: `done` is a one-cycle pulse that comes exactly D rising edges after the edge that accepts `start`, where D counts every draw including rejected ones. Results hold until the next run, and `start` has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one mating step (idle only) |
| seed_load | input | 1 | Load `seed` into the LFSR (idle only) |
| seed | input | 32 | LFSR seed; zero is replaced by 1 |
| pop_flat | input | POP·12·NELEM | Population; chromosome i at bits [i·CW +: CW] |
| fit_flat | input | POP·FIT_W | Unsigned fitness; entry i at bits [i·FIT_W +: FIT_W] |
| best_idx | input | $clog2(POP) | Index of the fittest chromosome, excluded from mutation |
| mut_prob | input | 8 | Mutation gate threshold out of 256 |
| mut_flips | input | 4 | Bits inverted per mutation |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| par_a | output | $clog2(POP) | First parent index |
| par_b | output | $clog2(POP) | Second parent index |
| child_a | output | 12·NELEM | Offspring A |
| child_b | output | 12·NELEM | Offspring B |
| mut_we | output | 1 | Mutated chromosome write strobe (with `done`) |
| mut_idx | output | $clog2(POP) | Index of the mutated chromosome |
| mut_data | output | 12·NELEM | Mutated chromosome |

## Verification
All results of a run appear together: `done`, the parents, both children and the mutation write are due exactly D edges after the start edge. D is the number of draws the run consumes, and rejected draws count. The bench plays the LFSR sequence forward for each run to get D and every expected value, then stores them in a queue together with the cycle number of the start edge. A monitor samples on the falling edge and compares each `done` against the head of the queue, checking the elapsed edge count as well as the data. A `done` that arrives with an empty queue, such as one caused by a `start` pulse during a run, is counted as a failure.

// File: rtl/ga_mate_unit.sv
module ga_mate_unit #(
  parameter int NELEM = 4,
  parameter int POP   = 6,
  parameter int FIT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         seed_load,
  input  logic [31:0]                  seed,
  input  logic [POP*NELEM*12-1:0]      pop_flat,
  input  logic [POP*FIT_W-1:0]         fit_flat,
  input  logic [$clog2(POP)-1:0]       best_idx,
  input  logic [7:0]                   mut_prob,
  input  logic [3:0]                   mut_flips,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(POP)-1:0]       par_a,
  output logic [$clog2(POP)-1:0]       par_b,
  output logic [NELEM*12-1:0]          child_a,
  output logic [NELEM*12-1:0]          child_b,
  output logic                         mut_we,
  output logic [$clog2(POP)-1:0]       mut_idx,
  output logic [NELEM*12-1:0]          mut_data
);
  localparam int CW = NELEM * 12;
  localparam int IW = $clog2(POP);
  localparam int PW = $clog2(CW);
  localparam logic [IW:0] POP_L = POP[IW:0];
  localparam logic [PW:0] CW_L  = CW[PW:0];
  localparam logic [31:0] TAPS  = 32'h80200003;

  typedef enum logic [3:0] {
    S_IDLE, S_T1A, S_T1B, S_T2A, S_T2B, S_CX1, S_CX2, S_MSEL, S_MGATE, S_MFLIP
  } st_t;

  st_t            st;
  logic [31:0]    lfsr;
  logic [IW-1:0]  cand, msel, best_q;
  logic [PW-1:0]  p1;
  logic [CW-1:0]  mreg, mask, nflip;
  logic [3:0]     fcnt, flips_q;
  logic [7:0]     prob_q;

  function automatic logic [CW-1:0] chrom(input logic [IW-1:0] i);
    return pop_flat[int'(i)*CW +: CW];
  endfunction

  function automatic logic [FIT_W-1:0] fit(input logic [IW-1:0] i);
    return fit_flat[int'(i)*FIT_W +: FIT_W];
  endfunction

  wire [31:0]   lfsr_nx = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? TAPS : 32'd0);
  wire [IW-1:0] ridx    = lfsr[IW-1:0];
  wire [PW-1:0] rpos    = lfsr[PW-1:0];
  wire          idx_ok  = {1'b0, ridx} < POP_L;
  wire          pos_ok  = {1'b0, rpos} < CW_L;
  wire [IW-1:0] winner  = (fit(ridx) > fit(cand)) ? ridx : cand;
  wire [PW-1:0] lo      = (p1 < rpos) ? p1 : rpos;
  wire [PW-1:0] hi      = (p1 < rpos) ? rpos : p1;

  assign busy  = (st != S_IDLE);
  assign nflip = mreg ^ ({{(CW-1){1'b0}}, 1'b1} << rpos);

  always_comb begin
    for (int i = 0; i < CW; i++)
      mask[i] = (PW'(i) >= lo) && (PW'(i) <= hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lfsr <= 32'd1;
      done <= 1'b0;
      mut_we <= 1'b0;
      cand <= '0;
      msel <= '0;
      best_q <= '0;
      p1 <= '0;
      mreg <= '0;
      fcnt <= '0;
      flips_q <= '0;
      prob_q <= '0;
      par_a <= '0;
      par_b <= '0;
      child_a <= '0;
      child_b <= '0;
      mut_idx <= '0;
      mut_data <= '0;
    end else begin
      done <= 1'b0;
      mut_we <= 1'b0;
      if (busy) lfsr <= lfsr_nx;
      case (st)
        S_IDLE: begin
          if (seed_load) lfsr <= (seed == 32'd0) ? 32'd1 : seed;
          if (start) begin
            best_q <= best_idx;
            prob_q <= mut_prob;
            flips_q <= mut_flips;
            st <= S_T1A;
          end
        end
        S_T1A: if (idx_ok) begin cand <= ridx; st <= S_T1B; end
        S_T1B: if (idx_ok) begin par_a <= winner; st <= S_T2A; end
        S_T2A: if (idx_ok) begin cand <= ridx; st <= S_T2B; end
        S_T2B: if (idx_ok) begin
          if (winner == par_a) st <= S_T2A;
          else begin par_b <= winner; st <= S_CX1; end
        end
        S_CX1: if (pos_ok) begin p1 <= rpos; st <= S_CX2; end
        S_CX2: if (pos_ok) begin
          child_a <= (chrom(par_a) & ~mask) | (chrom(par_b) & mask);
          child_b <= (chrom(par_b) & ~mask) | (chrom(par_a) & mask);
          st <= S_MSEL;
        end
        S_MSEL: if (idx_ok) begin
          if (ridx == best_q) begin done <= 1'b1; st <= S_IDLE; end
          else begin msel <= ridx; st <= S_MGATE; end
        end
        S_MGATE: begin
          if (lfsr[7:0] < prob_q) begin
            if (flips_q == 4'd0) begin
              mut_data <= chrom(msel);
              mut_idx <= msel;
              mut_we <= 1'b1;
              done <= 1'b1;
              st <= S_IDLE;
            end else begin
              mreg <= chrom(msel);
              fcnt <= 4'd0;
              st <= S_MFLIP;
            end
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_MFLIP: if (pos_ok) begin
          if (fcnt + 4'd1 == flips_q) begin
            mut_data <= nflip;
            mut_idx <= msel;
            mut_we <= 1'b1;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            mreg <= nflip;
            fcnt <= fcnt + 4'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 32'd0);
  a_r3_parent_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, par_a} < POP_L) && ({1'b0, par_b} < POP_L));
  a_r5_parents_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> par_a != par_b);
  a_r8_best_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    mut_we |-> mut_idx != best_q);
  a_r10_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    mut_we |-> done);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_end_of_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/ga_mate_unit_tb.sv
module ga_mate_unit_tb;
  localparam int NELEM = 4;
  localparam int POP   = 6;
  localparam int FIT_W = 8;
  localparam int CW    = NELEM * 12;
  localparam int IW    = $clog2(POP);

  typedef struct {
    int            pa, pb, mi, lat;
    logic [CW-1:0] ca, cb, md;
    bit            we;
    longint        t0;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, seed_load = 1'b0;
  logic [31:0] seed = '0;
  logic [POP*CW-1:0] pop_flat = '0;
  logic [POP*FIT_W-1:0] fit_flat = '0;
  logic [IW-1:0] best_idx = '0;
  logic [7:0] mut_prob = '0;
  logic [3:0] mut_flips = '0;
  logic busy, done, mut_we;
  logic [IW-1:0] par_a, par_b, mut_idx;
  logic [CW-1:0] child_a, child_b, mut_data;

  logic [CW-1:0] pop_m [POP];
  logic [FIT_W-1:0] fit_m [POP];
  logic [31:0] m_lfsr;
  exp_t q[$];
  longint cyc = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ga_mate_unit #(.NELEM(NELEM), .POP(POP), .FIT_W(FIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed(seed),
    .pop_flat(pop_flat), .fit_flat(fit_flat), .best_idx(best_idx),
    .mut_prob(mut_prob), .mut_flips(mut_flips), .busy(busy), .done(done),
    .par_a(par_a), .par_b(par_b), .child_a(child_a), .child_b(child_b),
    .mut_we(mut_we), .mut_idx(mut_idx), .mut_data(mut_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h80200003 : 32'd0);
  endfunction

  task automatic draw_idx(inout logic [31:0] l, inout int d, output int v);
    forever begin
      v = int'(l[IW-1:0]); l = nxt(l); d++;
      if (v < POP) break;
    end
  endtask

  task automatic draw_pos(inout logic [31:0] l, inout int d, output int v);
    forever begin
      v = int'(l[5:0]); l = nxt(l); d++;
      if (v < CW) break;
    end
  endtask

  task automatic tourney(inout logic [31:0] l, inout int d, output int w);
    int a, b;
    draw_idx(l, d, a);
    draw_idx(l, d, b);
    w = (fit_m[b] > fit_m[a]) ? b : a;
  endtask

  task automatic model(output exp_t e);
    logic [31:0] l = m_lfsr;
    int d = 0, p1, p2, lo, hi, ms, p;
    logic [7:0] g;
    tourney(l, d, e.pa);
    do tourney(l, d, e.pb); while (e.pb == e.pa);
    draw_pos(l, d, p1);
    draw_pos(l, d, p2);
    lo = (p1 < p2) ? p1 : p2;
    hi = (p1 < p2) ? p2 : p1;
    for (int i = 0; i < CW; i++) begin
      e.ca[i] = (i >= lo && i <= hi) ? pop_m[e.pb][i] : pop_m[e.pa][i];
      e.cb[i] = (i >= lo && i <= hi) ? pop_m[e.pa][i] : pop_m[e.pb][i];
    end
    e.we = 1'b0; e.mi = 0; e.md = '0;
    draw_idx(l, d, ms);
    if (ms != int'(best_idx)) begin
      g = l[7:0]; l = nxt(l); d++;
      if (g < mut_prob) begin
        e.we = 1'b1; e.mi = ms; e.md = pop_m[ms];
        for (int f = 0; f < int'(mut_flips); f++) begin
          draw_pos(l, d, p);
          e.md[p] = ~e.md[p];
        end
      end
    end
    e.lat = d;
    m_lfsr = l;
  endtask

  task automatic load_seed(input logic [31:0] v);
    @(negedge clk); seed = v; seed_load = 1'b1;
    @(negedge clk); seed_load = 1'b0;
    m_lfsr = (v == 32'd0) ? 32'd1 : v;
  endtask

  task automatic run(input bit poke);
    exp_t e;
    @(negedge clk);
    for (int i = 0; i < POP; i++) begin
      pop_flat[i*CW +: CW] = pop_m[i];
      fit_flat[i*FIT_W +: FIT_W] = fit_m[i];
    end
    model(e);
    start = 1'b1;
    @(posedge clk); #1;
    e.t0 = cyc;
    q.push_back(e);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R11", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - e.t0 == longint'(e.lat), "R11", "latency", cyc - e.t0, e.lat);
        chk(int'(par_a) == e.pa, "R4", "par_a", par_a, e.pa);
        chk(int'(par_b) == e.pb && par_a != par_b, "R5", "par_b", par_b, e.pb);
        chk(child_a == e.ca, "R7", "child_a", child_a, e.ca);
        chk(child_b == e.cb, "R6", "child_b", child_b, e.cb);
        chk(mut_we == e.we, "R8", "mut_we", mut_we, e.we);
        if (e.we) begin
          chk(int'(mut_idx) == e.mi, "R9", "mut_idx", mut_idx, e.mi);
          chk(mut_data == e.md, "R10", "mut_data", mut_data, e.md);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(mut_we == 1'b0, "R1", "mut_we after reset", mut_we, 0);
    m_lfsr = 32'd1;
    for (int r = 0; r < 28; r++) begin
      if (r == 6) load_seed(32'd0);
      else if (r % 4 == 3) load_seed($urandom() | 32'h1);
      for (int i = 0; i < POP; i++) begin
        pop_m[i] = {$urandom(), $urandom()};
        fit_m[i] = (r % 3 == 0) ? 8'd50 : 8'($urandom());
      end
      best_idx = IW'(r % POP);
      mut_prob = (r % 5 == 1) ? 8'd0 : ((r % 2 == 0) ? 8'd255 : 8'd180);
      mut_flips = 4'(r % 5);
      run(r == 5 || r == 17);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule